// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block sits in front of a timer counter and decides, cycle by cycle, whether the counter steps, which way it steps, and whether it is cleared or started. A 3-bit mode field chooses the behaviour. The choices are free running, three quadrature encoder variants, a trigger-driven clear, gated counting, a trigger-started run and counting on edges of an external trigger. The trigger comes from one of four external inputs, picked by a 2-bit select field. The counter is included: it counts up or down and reloads from a programmable limit.

The encoder channels and the trigger inputs each pass through a two-flip-flop synchroniser and one further stage for edge detection. The decoder registers its strobes, and the counter acts on them one cycle later. A level change on an external pin therefore reaches the count about four clock edges after it occurs. The block has no data stream, so every pin is a plain control or status signal and there is no valid/ready handshake. Software sets `cnt_en`, the mode, the select field, the software direction and the reload value. These are used as they are, without synchronisation.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: After reset, `count_o` is 0 and `step_o`, `down_o`, `clr_o` and `start_o` are all low.
- R2: In mode 0 the counter takes one step per clock while `cnt_en` is high. The direction is `sw_down` (0 counts up, 1 counts down). The count never changes without a step or a clear.
- R3: Counting up from a value equal to or above `reload` gives 0. Counting down from 0 gives `reload`. A step otherwise adds or subtracts one.
- R4: Mode 1 steps on every edge of channel A and mode 2 on every edge of channel B. The quadrature phase order for up is AB = 00, 10, 11, 01. An A edge counts up when A differs from B after the edge. A B edge counts up when the two are equal after the edge. `down_o` reports the last counted direction (1 means down).
- R5: Mode 3 steps on the edges of both channels, which gives four counts per full encoder cycle. If both channels change in the same cycle, the change is ignored and the count holds.
- R6: In mode 4 a rising edge of the selected trigger pulses `clr_o` for one cycle and the count becomes 0. No stepping happens in this mode, and a clear never comes together with a step.
- R7: In mode 5 the counter takes one step for each cycle in which the selected trigger is high. The direction is set by `sw_down`.
- R8: In mode 6, the first rising trigger edge while `cnt_en` is high pulses `start_o` once. From then on the counter steps every cycle. Later trigger edges are ignored. Dropping `cnt_en` stops the count and re-arms the start.
- R9: In mode 7 each rising edge of the selected trigger produces exactly one step.
- R10: `trig_sel` values 0 to 3 select `trig_in[trig_sel]`. Activity on the unselected trigger inputs has no effect on the count.
- R11: While `cnt_en` is low, no mode steps, clears or starts the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Software count enable |
| slave_mode | input | 3 | Mode field, 0 to 7 |
| trig_sel | input | 2 | Trigger input select |
| sw_down | input | 1 | Direction used outside encoder modes, 1 = down |
| enc_a | input | 1 | Encoder channel A |
| enc_b | input | 1 | Encoder channel B |
| trig_in | input | 4 | External trigger inputs |
| reload | input | CW | Auto-reload limit |
| step_o | output | 1 | Count-enable strobe to the counter |
| down_o | output | 1 | Count direction, 1 = down |
| clr_o | output | 1 | Counter-reset strobe |
| start_o | output | 1 | Counter-start strobe |
| count_o | output | CW | Counter value |

## Verification
The bench sweeps every mode and every trigger select, and checks each result against an arithmetic model of the counter. For encoder modes, a quadrature direction rule with inverted polarity would show up as a count going the wrong way. A decoder that treated a simultaneous change of both channels as a step would add one count per such change. A trigger multiplexer with a swapped or stuck index would count the noise that the bench drives on the unselected inputs. In trigger mode, the bench toggles the trigger a second time: a design that re-armed on that edge would emit an extra start pulse. At the reload limit, the bench counts up and down past the boundary, where an off-by-one wrap would leave the count one step away from the model.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [2:0] {
    SM_FREE   = 3'd0,
    SM_ENC_A  = 3'd1,
    SM_ENC_B  = 3'd2,
    SM_ENC_AB = 3'd3,
    SM_CLEAR  = 3'd4,
    SM_GATED  = 3'd5,
    SM_START  = 3'd6,
    SM_EXTCLK = 3'd7
  } slave_mode_e;
endpackage

// File: rtl/tsc_sync.sv
// Two-stage synchroniser plus one history stage for edge detection.
module tsc_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        lvl_o[i]  <= 1'b0;
        prev_o[i] <= 1'b0;
      end else begin
        meta_q[i] <= async_i[i];
        lvl_o[i]  <= meta_q[i];
        prev_o[i] <= lvl_o[i];
      end
    end
  end
endmodule

// File: rtl/tsc_mode_dec.sv
// Mode decoder: turns synchronised levels and edges into registered strobes.
module tsc_mode_dec
  import tsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  slave_mode_e mode,
  input  logic        sw_down,
  input  logic        a_lvl,
  input  logic        a_tog,
  input  logic        b_lvl,
  input  logic        b_tog,
  input  logic        t_lvl,
  input  logic        t_rise,
  output logic        step_q,
  output logic        down_q,
  output logic        clr_q,
  output logic        start_q
);
  logic started_q, started_d;
  logic step_d, down_d, clr_d, start_d;
  logic a_down, b_down;

  // quadrature rule: A edge is up when A != B afterwards, B edge when A == B
  assign a_down = ~(a_lvl ^ b_lvl);
  assign b_down = a_lvl ^ b_lvl;

  always_comb begin
    step_d    = 1'b0;
    down_d    = sw_down;
    clr_d     = 1'b0;
    start_d   = 1'b0;
    started_d = 1'b0;
    unique case (mode)
      SM_FREE:   step_d = en;
      SM_ENC_A: begin
        down_d = down_q;
        if (en && a_tog) begin
          step_d = 1'b1;
          down_d = a_down;
        end
      end
      SM_ENC_B: begin
        down_d = down_q;
        if (en && b_tog) begin
          step_d = 1'b1;
          down_d = b_down;
        end
      end
      SM_ENC_AB: begin
        down_d = down_q;
        if (en && (a_tog ^ b_tog)) begin
          step_d = 1'b1;
          down_d = a_tog ? a_down : b_down;
        end
      end
      SM_CLEAR:  clr_d  = en && t_rise;
      SM_GATED:  step_d = en && t_lvl;
      SM_START: begin
        started_d = en && (started_q || t_rise);
        start_d   = en && !started_q && t_rise;
        step_d    = en && started_q;
      end
      SM_EXTCLK: step_d = en && t_rise;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q    <= 1'b0;
      down_q    <= 1'b0;
      clr_q     <= 1'b0;
      start_q   <= 1'b0;
      started_q <= 1'b0;
    end else begin
      step_q    <= step_d;
      down_q    <= down_d;
      clr_q     <= clr_d;
      start_q   <= start_d;
      started_q <= started_d;
    end
  end
endmodule

// File: rtl/tsc_counter.sv
// Up/down counter with auto-reload limit.
module tsc_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          down,
  input  logic          clr,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= ZERO;
    end else if (clr) begin
      count <= ZERO;
    end else if (step) begin
      if (down) count <= (count == ZERO) ? reload : count - ONE;
      else      count <= (count >= reload) ? ZERO : count + ONE;
    end
  end
endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
  import tsc_pkg::*;
#(
  parameter int CW    = 16,
  parameter int NTRIG = 4,
  localparam int SEL_W = $clog2(NTRIG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [2:0]       slave_mode,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic             sw_down,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic [NTRIG-1:0] trig_in,
  input  logic [CW-1:0]    reload,
  output logic             step_o,
  output logic             down_o,
  output logic             clr_o,
  output logic             start_o,
  output logic [CW-1:0]    count_o
);
  localparam int NIN = NTRIG + 2;

  logic [NIN-1:0]   lvl, prev;
  logic [NTRIG-1:0] t_lvl_v, t_prev_v;
  logic             t_lvl, t_rise;

  tsc_sync #(.W(NIN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({trig_in, enc_b, enc_a}),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  assign t_lvl_v  = lvl[NIN-1:2];
  assign t_prev_v = prev[NIN-1:2];
  assign t_lvl    = t_lvl_v[trig_sel];
  assign t_rise   = t_lvl_v[trig_sel] & ~t_prev_v[trig_sel];

  tsc_mode_dec u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cnt_en),
    .mode   (slave_mode_e'(slave_mode)),
    .sw_down(sw_down),
    .a_lvl  (lvl[0]),
    .a_tog  (lvl[0] ^ prev[0]),
    .b_lvl  (lvl[1]),
    .b_tog  (lvl[1] ^ prev[1]),
    .t_lvl  (t_lvl),
    .t_rise (t_rise),
    .step_q (step_o),
    .down_q (down_o),
    .clr_q  (clr_o),
    .start_q(start_o)
  );

  tsc_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step_o),
    .down  (down_o),
    .clr   (clr_o),
    .reload(reload),
    .count (count_o)
  );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic [2:0]    slave_mode,
  input logic          step_o,
  input logic          down_o,
  input logic          clr_o,
  input logic          start_o,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] reload
);
  AST_STEP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_en) |-> !step_o && !clr_o && !start_o); // R11
  AST_START_IN_MODE6: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(slave_mode) == 3'd6); // R8
  AST_CLR_IN_MODE4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> $past(slave_mode) == 3'd4); // R6
  AST_CLR_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_o) |-> count_o == '0); // R6
  AST_NO_CLR_WITH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_o && step_o)); // R6
  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(step_o) && !$past(clr_o) |-> $stable(count_o)); // R2
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step_o) && !$past(down_o) && !$past(clr_o)
      && $past(count_o) == $past(reload) |-> count_o == '0); // R3
  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step_o) && $past(down_o) && !$past(clr_o)
      && $past(count_o) == '0 |-> count_o == $past(reload)); // R3
endmodule

bind tmr_slave_ctrl tsc_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en    (cnt_en),
  .slave_mode(slave_mode),
  .step_o    (step_o),
  .down_o    (down_o),
  .clr_o     (clr_o),
  .start_o   (start_o),
  .count_o   (count_o),
  .reload    (reload)
);

// File: tb/tmr_slave_ctrl_tb_top.sv
module tmr_slave_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [2:0]  slave_mode = 3'd0;
  logic [1:0]  trig_sel = 2'd0;
  logic        sw_down = 1'b0;
  logic        enc_a = 1'b0;
  logic        enc_b = 1'b0;
  logic [3:0]  trig_in = 4'd0;
  logic [15:0] reload = 16'd50;
  logic        step_o, down_o, clr_o, start_o;
  logic [15:0] count_o;

  int nchk = 0, nerr = 0;
  int expc = 0;
  int n_start = 0, n_clr = 0;
  int ph = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_slave_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .slave_mode(slave_mode),
    .trig_sel(trig_sel), .sw_down(sw_down), .enc_a(enc_a), .enc_b(enc_b),
    .trig_in(trig_in), .reload(reload), .step_o(step_o), .down_o(down_o),
    .clr_o(clr_o), .start_o(start_o), .count_o(count_o)
  );

  always @(negedge clk) begin
    if (start_o) n_start++;
    if (clr_o)   n_clr++;
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int adv(int c, bit dn);
    int rl = int'(reload);
    if (dn) return (c == 0) ? rl : c - 1;
    return (c >= rl) ? 0 : c + 1;
  endfunction

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(int m);
    cnt_en = 1'b0;
    wt(2);
    slave_mode = 3'(m);
    wt(2);
  endtask

  // one quadrature phase step; model counts per requirement R4 / R5
  task automatic enc_go(int m, bit up, int n);
    for (int i = 0; i < n; i++) begin
      bit olda = enc_a;
      bit cha;
      ph = (ph + (up ? 1 : 3)) % 4;
      enc_a = (ph == 1 || ph == 2);
      enc_b = (ph == 2 || ph == 3);
      cha = (enc_a != olda);
      if ((m == 1 && cha) || (m == 2 && !cha) || m == 3) expc = adv(expc, !up);
      wt(4);
    end
    wt(4);
  endtask

  initial begin
    wt(3);
    rst_n = 1'b1;
    wt(2);
    // R1 reset state
    chk("R1 count", int'(count_o), 0);
    chk("R1 strobes", int'({step_o, down_o, clr_o, start_o}), 0);

    // R2 free running, up then down
    sw_down = 0; cnt_en = 1; wt(17); cnt_en = 0; wt(4);
    for (int i = 0; i < 17; i++) expc = adv(expc, 0);
    chk("R2 up", int'(count_o), expc);
    sw_down = 1; cnt_en = 1; wt(6); cnt_en = 0; wt(4);
    for (int i = 0; i < 6; i++) expc = adv(expc, 1);
    chk("R2 down", int'(count_o), expc);
    chk("R2 dir", int'(down_o), 1);

    // R3 wrap at small reload, both directions
    reload = 16'd9;
    sw_down = 0; cnt_en = 1; wt(25); cnt_en = 0; wt(4);
    for (int i = 0; i < 25; i++) expc = adv(expc, 0);
    chk("R3 wrap up", int'(count_o), expc);
    sw_down = 1; cnt_en = 1; wt(23); cnt_en = 0; wt(4);
    for (int i = 0; i < 23; i++) expc = adv(expc, 1);
    chk("R3 wrap down", int'(count_o), expc);
    reload = 16'd200;
    sw_down = 0;

    // R4 / R5 encoder modes
    for (int m = 1; m <= 3; m++) begin
      set_mode(m);
      cnt_en = 1;
      enc_go(m, 1, 9);
      chk(m == 3 ? "R5 enc up" : "R4 enc up", int'(count_o), expc);
      chk("R4 dir up", int'(down_o), 0);
      enc_go(m, 0, 6);
      chk(m == 3 ? "R5 enc down" : "R4 enc down", int'(count_o), expc);
      chk("R4 dir down", int'(down_o), 1);
      if (m == 3) begin
        enc_a = ~enc_a; enc_b = ~enc_b; wt(6);
        chk("R5 both flip", int'(count_o), expc);
        enc_a = ~enc_a; enc_b = ~enc_b; wt(6);
        chk("R5 both flip back", int'(count_o), expc);
      end
    end
    // R5 four counts per cycle from a known start
    enc_go(3, 1, 8);
    chk("R5 two cycles", int'(count_o), expc);

    // R7 / R10 gated, every select, noise on the other inputs
    for (int s = 0; s < 4; s++) begin
      set_mode(5);
      trig_sel = 2'(s);
      sw_down = s[0];
      cnt_en = 1;
      for (int k = 0; k < 6; k++) begin
        trig_in = 4'(k % 2 ? 4'hF : 4'h0) & ~(4'b1 << s);
        wt(3);
      end
      trig_in = 4'h0; wt(4);
      chk("R10 gated noise", int'(count_o), expc);
      trig_in[s] = 1'b1; wt(s * 3 + 5); trig_in[s] = 1'b0; wt(5);
      for (int i = 0; i < s * 3 + 5; i++) expc = adv(expc, s[0]);
      chk("R7 gated", int'(count_o), expc);
    end
    sw_down = 0;

    // R9 / R10 external clock, every select
    for (int s = 0; s < 4; s++) begin
      set_mode(7);
      trig_sel = 2'(s);
      cnt_en = 1;
      for (int p = 0; p < s + 3; p++) begin
        trig_in = (4'b1 << s) | ((p % 2) ? ~(4'b1 << s) : 4'h0); wt(3);
        trig_in = 4'h0; wt(3);
        expc = adv(expc, 0);
      end
      wt(4);
      chk("R9 extclk", int'(count_o), expc);
    end

    // R11 disabled: gated and external clock edges ignored
    set_mode(7);
    for (int p = 0; p < 4; p++) begin trig_in = 4'hF; wt(3); trig_in = 4'h0; wt(3); end
    set_mode(5);
    trig_in = 4'hF; wt(8); trig_in = 4'h0; wt(4);
    chk("R11 disabled", int'(count_o), expc);

    // R6 clear on trigger edge, no stepping in this mode
    set_mode(4);
    trig_sel = 2'd2;
    cnt_en = 1; wt(8);
    chk("R6 hold", int'(count_o), expc);
    trig_in[2] = 1'b1; wt(6); trig_in[2] = 1'b0; wt(4);
    expc = 0;
    chk("R6 cleared", int'(count_o), 0);
    chk("R6 one pulse", n_clr, 1);
    cnt_en = 0; wt(2);
    trig_in[2] = 1'b1; wt(6); trig_in[2] = 1'b0; wt(4);
    chk("R11 no clear when off", n_clr, 1);

    // R8 start mode
    set_mode(6);
    trig_sel = 2'd1;
    cnt_en = 1; wt(10);
    chk("R8 idle", int'(count_o), 0);
    trig_in[1] = 1'b1; wt(12);
    chk("R8 start pulse", n_start, 1);
    begin
      int c1, c2;
      c1 = int'(count_o);
      trig_in[1] = 1'b0; wt(4); trig_in[1] = 1'b1; wt(6);
      c2 = int'(count_o);
      chk("R8 runs on", c2, (c1 + 10) % 201);
      chk("R8 later edge ignored", n_start, 1);
      cnt_en = 0; wt(4);
      c1 = int'(count_o); wt(10);
      chk("R8 stops", int'(count_o), c1);
    end
    trig_in[1] = 1'b0; wt(4);
    cnt_en = 1; wt(3);
    trig_in[1] = 1'b1; wt(6);
    chk("R8 rearm", n_start, 2);
    cnt_en = 0; trig_in = 4'h0; wt(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule